// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading up to two descriptors from a page table in memory. It accepts one request at a time, with the virtual address, the kind of access (load, store or fetch) and a user-mode flag. It also takes the live values of four configuration registers: control, table base, domain access and process identifier. Low addresses are first relocated by the process identifier. The walker then reads a first-level descriptor and, when the descriptor points to a second-level table, a page descriptor.

A completed walk produces one of two results. On success it gives the physical address, read and write permission flags, and an all-zero status. On failure it gives a status byte that combines a fault code with the 2-bit domain access value. Descriptor reads go through a simple request/valid memory port. The request is held until the data is returned. Translation caching is left to the surrounding logic.

Top module: `vm_table_walker`

## Requirements
- R1: After reset `done` and `memReq` are 0, `reqReady` is 1 and `faultStatus` is 0.
- R2: A request address below `RELOC_LIMIT` (default 0x0200_0000) has `pidReg` added before any other use. Addresses at or above the limit pass unchanged.
- R3: With `ctrlReg[0]` = 0 no memory read is made. `done` rises in the cycle after the request is accepted, with `physAddr` equal to the relocated address, both permissions set and status 0.
- R4: The first-level read address is {tableBase[31:14], va[31:20], 2'b00}. `memReq` stays high with a stable `memAddr` until `memValid` is seen, and `reqReady` is low while a walk runs.
- R5: A first-level descriptor of type 0 (bits 1:0) gives fault code 5. Every fault reports status {2'b00, domain access, code}, with zero address and no permission. The domain access is `domainReg` bits [2d+1:2d], where d is descriptor bits 8:5.
- R6: A domain access of 0 or 2 gives code 9 for a section (type 2) and code 11 for a coarse table (type 1) or fine table (type 3).
- R7: A section maps {desc[31:20], va[19:0]}. Its permission field is desc[11:10], and a permission refusal gives code 13.
- R8: The second-level read address is {l1desc[31:10], va[19:12], 2'b00}. Page type 1 (64K) maps {desc[31:16], va[15:0]} and type 2 (4K) maps {desc[31:12], va[11:0]}. Both take their permission field at bit 4+2*va[15:14]. A page permission refusal gives code 15.
- R9: Page type 3 (1K) maps {desc[31:10], va[9:0]} with permission desc[5:4] under a fine table. Under a coarse table it is a code 7 fault. A page type 0 is also a code 7 fault.
- R10: Domain access 3 grants read and write whatever the permission field holds.
- R11: Under client access (1), the permission field rules are as follows. Field 1 gives read/write to privileged accesses and refuses user accesses. Field 2 gives privileged read/write, user read, and refuses user stores. Field 3 gives read/write to all.
- R12: Field 0 refuses every store (access code 1). A load or fetch is then decided by ctrlReg[9:8]. With 1 it gets read-only if privileged and is refused if user. With 2 it gets read-only. With 0 or 3 it is refused.
- R13: `done` is a one-cycle pulse, and the result outputs hold their values until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (taken when reqReady is high) |
| reqAddr | input | 32 | Virtual address |
| reqAccess | input | 2 | 0 load, 1 store, 2 fetch |
| reqUser | input | 1 | Access made in user mode |
| ctrlReg | input | 32 | Bit 0 enables translation; bits 9:8 select read rights for permission field 0 |
| tableBase | input | 32 | First-level table base (bits 31:14 used) |
| domainReg | input | 32 | Sixteen 2-bit domain access values |
| pidReg | input | 32 | Relocation offset for low addresses |
| reqReady | output | 1 | Walker idle |
| memReq | output | 1 | Descriptor read request |
| memAddr | output | 32 | Descriptor address |
| memValid | input | 1 | Descriptor data valid |
| memData | input | 32 | Descriptor data |
| done | output | 1 | One-cycle completion strobe |
| physAddr | output | 32 | Physical address (0 on fault) |
| permRead | output | 1 | Read granted |
| permWrite | output | 1 | Write granted |
| faultStatus | output | 8 | 0 on success, else {2'b00, domain access, code} |

## Verification
The bench builds the walker with the default relocation limit of 0x0200_0000. This places addresses on both sides of the relocation boundary within reach, with translation both off and on. It answers descriptor reads after zero and after three wait cycles, so both the immediate-data path and the held-request path are exercised. Descriptors at an unexpected address are flagged. Every descriptor kind, every domain access value and every permission field are reached through sections and through 64K, 4K and 1K pages under coarse and fine tables.

// File: rtl/vmw_pkg.sv
package vmw_pkg;
  localparam int ADDR_W = 32;
  localparam int STAT_W = 8;

  localparam logic [3:0] FLT_SEC_XLATE  = 4'd5;
  localparam logic [3:0] FLT_PAGE_XLATE = 4'd7;
  localparam logic [3:0] FLT_SEC_DOM    = 4'd9;
  localparam logic [3:0] FLT_PAGE_DOM   = 4'd11;
  localparam logic [3:0] FLT_SEC_PERM   = 4'd13;
  localparam logic [3:0] FLT_PAGE_PERM  = 4'd15;

  localparam logic [1:0] ACC_STORE = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_FIN
  } walkState_t;

  typedef struct packed {
    logic loadReq;
    logic bypass;
    logic takeL1;
    logic takeL2;
    logic selL2;
  } walkStrobe_t;

  // Returns {read, write}
  function automatic logic [1:0] permCheck(
    input logic [1:0] ap,
    input logic [1:0] domAcc,
    input logic       isWrite,
    input logic       isUser,
    input logic [1:0] sysRom
  );
    logic [1:0] r;
    r = 2'b00;
    if (domAcc == 2'd3) begin
      r = 2'b11;
    end else begin
      case (ap)
        2'd0: begin
          if (!isWrite) begin
            case (sysRom)
              2'd1:    r = isUser ? 2'b00 : 2'b10;
              2'd2:    r = 2'b10;
              default: r = 2'b00;
            endcase
          end
        end
        2'd1:    r = isUser ? 2'b00 : 2'b11;
        2'd2:    r = isUser ? (isWrite ? 2'b00 : 2'b10) : 2'b11;
        default: r = 2'b11;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/vmw_ctrl.sv
module vmw_ctrl
  import vmw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        mmuEnable,
  input  logic        memValid,
  input  logic        l1Terminal,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        reqReady,
  output logic        done
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    memReq    = 1'b0;
    reqReady  = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          if (!mmuEnable) begin
            strobe.bypass = 1'b1;
            nextState     = ST_FIN;
          end else begin
            nextState = ST_L1;
          end
        end
      end
      ST_L1: begin
        memReq = 1'b1;
        if (memValid) begin
          strobe.takeL1 = 1'b1;
          nextState     = l1Terminal ? ST_FIN : ST_L2;
        end
      end
      ST_L2: begin
        memReq       = 1'b1;
        strobe.selL2 = 1'b1;
        if (memValid) begin
          strobe.takeL2 = 1'b1;
          nextState     = ST_FIN;
        end
      end
      default: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/vmw_dpath.sv
module vmw_dpath
  import vmw_pkg::*;
#(
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqAccess,
  input  logic                reqUser,
  input  logic [31:0]         ctrlReg,
  input  logic [31:0]         tableBase,
  input  logic [31:0]         domainReg,
  input  logic [31:0]         pidReg,
  input  logic [31:0]         memData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                l1Terminal,
  output logic [ADDR_W-1:0]   physAddr,
  output logic                permRead,
  output logic                permWrite,
  output logic [STAT_W-1:0]   faultStatus
);
  logic [ADDR_W-1:0] vaReg;
  logic              isWriteReg, isUserReg;
  logic [31:0]       l1DescReg;
  logic [1:0]        domAccReg;

  // relocation of low addresses
  logic [ADDR_W-1:0] relocAddr;
  assign relocAddr = (reqAddr < RELOC_LIMIT) ? reqAddr + pidReg : reqAddr;

  // descriptor addresses
  always_comb begin
    if (strobe.selL2) memAddr = {l1DescReg[31:10], vaReg[19:12], 2'b00};
    else              memAddr = {tableBase[31:14], vaReg[31:20], 2'b00};
  end

  // first-level decode
  logic [1:0]  l1Type, l1Dom, l1Perm;
  logic [3:0]  l1Code;
  logic [31:0] l1Phys;
  always_comb begin
    l1Type     = memData[1:0];
    l1Dom      = domainReg[{memData[8:5], 1'b0} +: 2];
    l1Perm     = 2'b00;
    l1Code     = 4'd0;
    l1Phys     = {memData[31:20], vaReg[19:0]};
    l1Terminal = 1'b1;
    if (l1Type == 2'd0) begin
      l1Code = FLT_SEC_XLATE;
    end else if (l1Dom == 2'd0 || l1Dom == 2'd2) begin
      l1Code = (l1Type == 2'd2) ? FLT_SEC_DOM : FLT_PAGE_DOM;
    end else if (l1Type == 2'd2) begin
      l1Perm = permCheck(memData[11:10], l1Dom, isWriteReg, isUserReg, ctrlReg[9:8]);
      if (l1Perm == 2'b00) l1Code = FLT_SEC_PERM;
    end else begin
      l1Terminal = 1'b0;
    end
  end

  // second-level decode
  logic [1:0]  l2Ap, l2Perm;
  logic [3:0]  l2Code;
  logic [31:0] l2Phys;
  always_comb begin
    l2Ap   = 2'b00;
    l2Perm = 2'b00;
    l2Code = 4'd0;
    l2Phys = 32'd0;
    case (vaReg[15:14])
      2'd0:    l2Ap = memData[5:4];
      2'd1:    l2Ap = memData[7:6];
      2'd2:    l2Ap = memData[9:8];
      default: l2Ap = memData[11:10];
    endcase
    case (memData[1:0])
      2'd0: l2Code = FLT_PAGE_XLATE;
      2'd1: l2Phys = {memData[31:16], vaReg[15:0]};
      2'd2: l2Phys = {memData[31:12], vaReg[11:0]};
      default: begin
        if (l1DescReg[1:0] == 2'd1) l2Code = FLT_PAGE_XLATE;
        l2Phys = {memData[31:10], vaReg[9:0]};
        l2Ap   = memData[5:4];
      end
    endcase
    if (l2Code == 4'd0) begin
      l2Perm = permCheck(l2Ap, domAccReg, isWriteReg, isUserReg, ctrlReg[9:8]);
      if (l2Perm == 2'b00) l2Code = FLT_PAGE_PERM;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg       <= '0;
      isWriteReg  <= 1'b0;
      isUserReg   <= 1'b0;
      l1DescReg   <= '0;
      domAccReg   <= '0;
      physAddr    <= '0;
      permRead    <= 1'b0;
      permWrite   <= 1'b0;
      faultStatus <= '0;
    end else begin
      if (strobe.loadReq) begin
        vaReg      <= relocAddr;
        isWriteReg <= (reqAccess == ACC_STORE);
        isUserReg  <= reqUser;
      end
      if (strobe.bypass) begin
        physAddr    <= relocAddr;
        permRead    <= 1'b1;
        permWrite   <= 1'b1;
        faultStatus <= '0;
      end
      if (strobe.takeL1) begin
        l1DescReg <= memData;
        domAccReg <= l1Dom;
        if (l1Terminal) begin
          if (l1Code != 4'd0) begin
            physAddr    <= '0;
            {permRead, permWrite} <= 2'b00;
            faultStatus <= {2'b00, l1Dom, l1Code};
          end else begin
            physAddr    <= l1Phys;
            {permRead, permWrite} <= l1Perm;
            faultStatus <= '0;
          end
        end
      end
      if (strobe.takeL2) begin
        if (l2Code != 4'd0) begin
          physAddr    <= '0;
          {permRead, permWrite} <= 2'b00;
          faultStatus <= {2'b00, domAccReg, l2Code};
        end else begin
          physAddr    <= l2Phys;
          {permRead, permWrite} <= l2Perm;
          faultStatus <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/vm_table_walker.sv
module vm_table_walker
  import vmw_pkg::*;
#(
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic [1:0]  reqAccess,
  input  logic        reqUser,
  input  logic [31:0] ctrlReg,
  input  logic [31:0] tableBase,
  input  logic [31:0] domainReg,
  input  logic [31:0] pidReg,
  output logic        reqReady,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memValid,
  input  logic [31:0] memData,
  output logic        done,
  output logic [31:0] physAddr,
  output logic        permRead,
  output logic        permWrite,
  output logic [7:0]  faultStatus
);
  walkStrobe_t strobe;
  logic        l1Terminal;

  vmw_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .mmuEnable  (ctrlReg[0]),
    .memValid   (memValid),
    .l1Terminal (l1Terminal),
    .strobe     (strobe),
    .memReq     (memReq),
    .reqReady   (reqReady),
    .done       (done)
  );

  vmw_dpath #(.RELOC_LIMIT(RELOC_LIMIT)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqAccess   (reqAccess),
    .reqUser     (reqUser),
    .ctrlReg     (ctrlReg),
    .tableBase   (tableBase),
    .domainReg   (domainReg),
    .pidReg      (pidReg),
    .memData     (memData),
    .memAddr     (memAddr),
    .l1Terminal  (l1Terminal),
    .physAddr    (physAddr),
    .permRead    (permRead),
    .permWrite   (permWrite),
    .faultStatus (faultStatus)
  );
endmodule

// File: rtl/vmw_checker.sv
module vmw_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        memValid,
  input logic        done,
  input logic        permRead,
  input logic        permWrite,
  input logic [7:0]  faultStatus
);
  p_done_single_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

  p_fault_noperm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultStatus != 8'd0) |-> (!permRead && !permWrite));

  p_fault_format_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultStatus != 8'd0) |-> (faultStatus[0] && faultStatus[7:6] == 2'b00));

  p_grant_reads_r11: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultStatus == 8'd0) |-> permRead);

  p_hold_result_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !memValid && $past(!memValid)) |-> $stable(faultStatus));
endmodule

bind vm_table_walker vmw_checker uChecker (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .memReq      (memReq),
  .memAddr     (memAddr),
  .memValid    (memValid),
  .done        (done),
  .permRead    (permRead),
  .permWrite   (permWrite),
  .faultStatus (faultStatus)
);

// File: tb/vm_table_walker_test.sv
module vm_table_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBASE = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic [31:0] ctrlReg = '0;
  logic [31:0] tableBase = TBASE;
  logic [31:0] domainReg = '0;
  logic [31:0] pidReg = '0;
  logic        reqReady, memReq, done, permRead, permWrite;
  logic [31:0] memAddr, physAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic [7:0]  faultStatus;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] l1A, l1D, l2A, l2D;
  int  memDelay = 0;
  int  waitCnt = 0;
  int  memReads = 0;
  bit  addrBad = 0;
  int  lastWait = 0;

  vm_table_walker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqAccess(reqAccess), .reqUser(reqUser), .ctrlReg(ctrlReg),
    .tableBase(tableBase), .domainReg(domainReg), .pidReg(pidReg),
    .reqReady(reqReady), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .done(done),
    .physAddr(physAddr), .permRead(permRead), .permWrite(permWrite),
    .faultStatus(faultStatus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory responder
  always @(negedge clk) begin
    if (memReq && !memValid) begin
      if (waitCnt >= memDelay) begin
        memValid = 1'b1;
        memReads++;
        if (memAddr == l1A)      memData = l1D;
        else if (memAddr == l2A) memData = l2D;
        else begin
          memData = 32'hDEAD_BEEF;
          addrBad = 1'b1;
        end
      end else begin
        waitCnt++;
      end
    end else begin
      memValid = 1'b0;
      waitCnt  = 0;
    end
  end

  task automatic report(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // one walk; checks address formation, done pulse and result hold (R4, R13)
  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit usr,
                      input logic [31:0] ePhys, input bit eRd, input bit eWr,
                      input logic [7:0] eFault, input string tag);
    logic [31:0] gPhys;
    logic        gRd, gWr;
    logic [7:0]  gFault;
    int n;
    addrBad  = 0;
    memReads = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = va; reqAccess = acc; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    lastWait = n;
    gPhys = physAddr; gRd = permRead; gWr = permWrite; gFault = faultStatus;
    report({tag, " result"}, {gPhys, 6'd0, gRd, gWr, 8'd0, gFault},
           {ePhys, 6'd0, eRd, eWr, 8'd0, eFault});
    report({tag, " R4 descriptor address"}, {63'd0, addrBad}, 64'd0);
    @(negedge clk);
    report({tag, " R13 done pulse/hold"},
           {done, physAddr, 1'b0, permRead, permWrite, 21'd0, faultStatus},
           {1'b0, gPhys, 1'b0, gRd, gWr, 21'd0, gFault});
  endtask

  task automatic setL1(input logic [31:0] va, input logic [31:0] d);
    l1A = {TBASE[31:14], va[31:20], 2'b00};
    l1D = d;
  endtask

  task automatic setL2(input logic [31:0] va, input logic [31:0] d);
    l2A = {l1D[31:10], va[19:12], 2'b00};
    l2D = d;
  endtask

  task automatic testReset();
    report("R1 reset outputs", {60'd0, done, memReq, reqReady, 1'b0}, {60'd0, 4'b0010});
    report("R1 reset status", {56'd0, faultStatus}, 64'd0);
  endtask

  task automatic testBypass();
    ctrlReg = 32'h0; pidReg = 32'h0600_0000;
    l1A = 32'hFFFF_FFF0; l2A = 32'hFFFF_FFF4;
    walk(32'h0012_3456, 2'd1, 1'b1, 32'h0612_3456, 1, 1, 8'h00, "R2 R3 low relocated");
    report("R3 no memory read", memReads, 0);
    report("R3 done next cycle", lastWait, 0);
    walk(32'h0300_0010, 2'd0, 1'b0, 32'h0300_0010, 1, 1, 8'h00, "R2 high unchanged");
    walk(32'h01FF_FFFF, 2'd0, 1'b0, 32'h07FF_FFFF, 1, 1, 8'h00, "R2 boundary-1");
    walk(32'h0200_0000, 2'd0, 1'b0, 32'h0200_0000, 1, 1, 8'h00, "R2 at boundary");
  endtask

  task automatic testL1Faults();
    logic [31:0] va;
    va = 32'h1230_0000;
    ctrlReg = 32'h1; pidReg = 32'h0;
    domainReg = 32'h4000_0000;
    setL1(va, 32'h0000_01E0);
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h15, "R5 L1 type0");
    report("R5 one read", memReads, 1);
    domainReg = 32'h0;
    setL1(va, 32'h0000_0022);
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h09, "R6 section dom0");
    domainReg = 32'h8;
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h29, "R6 section dom2");
    domainReg = 32'h0;
    setL1(va, 32'h0000_0021);
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h0B, "R6 coarse dom0");
    setL1(va, 32'h0000_0023);
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h0B, "R6 fine dom0");
  endtask

  task automatic testSections();
    logic [31:0] va;
    va = 32'h1234_5678;
    ctrlReg = 32'h1; domainReg = 32'h4;
    setL1(va, 32'hABC0_0C22);
    walk(va, 2'd1, 1'b1, 32'hABC4_5678, 1, 1, 8'h00, "R7 R11 section ap3 user store");
    setL1(va, 32'hABC0_0422);
    walk(va, 2'd0, 1'b1, 0, 0, 0, 8'h1D, "R7 R11 ap1 user load");
    walk(va, 2'd1, 1'b0, 32'hABC4_5678, 1, 1, 8'h00, "R11 ap1 priv store");
    setL1(va, 32'hABC0_0822);
    walk(va, 2'd1, 1'b1, 0, 0, 0, 8'h1D, "R11 ap2 user store");
    walk(va, 2'd2, 1'b1, 32'hABC4_5678, 1, 0, 8'h00, "R11 ap2 user fetch");
    walk(va, 2'd1, 1'b0, 32'hABC4_5678, 1, 1, 8'h00, "R11 ap2 priv store");
  endtask

  task automatic testAp0();
    logic [31:0] va;
    va = 32'h1234_5678;
    domainReg = 32'h4;
    setL1(va, 32'hABC0_0022);
    ctrlReg = 32'h101;
    walk(va, 2'd1, 1'b0, 0, 0, 0, 8'h1D, "R12 ap0 store");
    walk(va, 2'd0, 1'b0, 32'hABC4_5678, 1, 0, 8'h00, "R12 sys1 priv load");
    walk(va, 2'd0, 1'b1, 0, 0, 0, 8'h1D, "R12 sys1 user load");
    ctrlReg = 32'h201;
    walk(va, 2'd2, 1'b1, 32'hABC4_5678, 1, 0, 8'h00, "R12 sys2 user fetch");
    ctrlReg = 32'h301;
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h1D, "R12 sys3 priv load");
    ctrlReg = 32'h001;
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h1D, "R12 sys0 priv load");
    domainReg = 32'hC;
    walk(va, 2'd1, 1'b1, 32'hABC4_5678, 1, 1, 8'h00, "R10 manager ap0 user store");
  endtask

  task automatic testPages();
    logic [31:0] va;
    va = 32'h1234_5678;
    ctrlReg = 32'h1; domainReg = 32'h4;
    memDelay = 3;
    setL1(va, 32'h0008_0021);
    setL2(va, 32'h7777_70C2);
    walk(va, 2'd1, 1'b1, 32'h7777_7678, 1, 1, 8'h00, "R8 4K sub1 ap3");
    report("R8 two reads", memReads, 2);
    setL2(va, 32'h7777_7F32);
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h1F, "R8 4K sub1 ap0");
    setL2(va, 32'h7777_7082);
    walk(va, 2'd1, 1'b1, 0, 0, 0, 8'h1F, "R8 R11 4K ap2 user store");
    walk(va, 2'd0, 1'b1, 32'h7777_7678, 1, 0, 8'h00, "R11 4K ap2 user load");
    setL2(va, 32'h5555_00C1);
    walk(va, 2'd1, 1'b1, 32'h5555_5678, 1, 1, 8'h00, "R8 64K page");
    setL2(va, 32'h3333_3C33);
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h17, "R9 1K under coarse");
    setL2(va, 32'h3333_3C30);
    walk(va, 2'd0, 1'b0, 0, 0, 0, 8'h17, "R9 L2 type0");
    memDelay = 0;
    setL1(va, 32'h0008_0023);
    setL2(va, 32'h3333_3C33);
    walk(va, 2'd1, 1'b1, 32'h3333_3E78, 1, 1, 8'h00, "R9 1K under fine");
    domainReg = 32'hC;
    setL2(va, 32'h3333_3C03);
    walk(va, 2'd1, 1'b1, 32'h3333_3E78, 1, 1, 8'h00, "R10 manager page");
  endtask

  task automatic testRelocOn();
    logic [31:0] reloc;
    ctrlReg = 32'h1; domainReg = 32'h4; pidReg = 32'h1230_0000;
    reloc = 32'h1240_0000;
    setL1(reloc, 32'h9990_0C22);
    walk(32'h0010_0000, 2'd0, 1'b0, 32'h9990_0000, 1, 1, 8'h00, "R2 relocation with walk");
    pidReg = 32'h0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBypass();
    testL1Faults();
    testSections();
    testAp0();
    testPages();
    testRelocOn();
    finishRun();
  end
endmodule